// File: doc/BRIEF.md
# Escalating Watchdog with Guarded Stop

This block supervises software by counting expiry pulses from one of several external periodic timers. While armed, each group of expiries moves it one step up a ladder of five stages. The first stage raises a local interrupt, stages two to four add a fast local interrupt and a remote interrupt, and the fifth stage emits a one-cycle request for a debug reset and/or a power-on reset. Each of these outputs has its own enable bit.

Software keeps the block quiet by restarting it before the ladder is climbed. A start command clears the stage and expiry counters and returns every output to its idle level. Stopping the watchdog is deliberately awkward. A stop command is honoured only when the write just before it placed the 16-bit key 0xC45A into the key register. While the watchdog is armed, its settings are frozen.

The register interface is write-only, with byte offsets 0x0 (settings), 0x8 (command) and 0xC (key). The settings word is also visible at all times on a read-back port.

Top module: `wdog_top`

## Requirements
- R1: After reset all five outputs are low, the settings read back as zero and the watchdog is disarmed.
- R2: A write to offset 0x0 while disarmed stores data bits 16:0 and nothing else. The field layout is:
  - bit 16: enables the power-on reset request.
  - bit 15: enables the debug reset request.
  - bit 14: enables the remote interrupt.
  - bit 13: enables the fast local interrupt.
  - bit 12: enables the local interrupt.
  - bits 11:4: period, in expiries per stage.
  - bits 3:0: source number.
  Bits 31:17 read back as zero.
- R3: Only the expiry input whose index equals the source field is counted. Pulses on other indices have no effect.
- R4: The stage advances by one each time `period` counted expiries have accumulated. A period of 0 means 256 expiries.
- R5: From stage 1 onward the local interrupt is high if bit 12 is set. It stays high until a stop or start command.
- R6: From stage 2 onward the fast local interrupt (bit 13) and the remote interrupt (bit 14) are high if enabled. They stay high until a stop or start command.
- R7: On entry to stage 5 the debug reset request (bit 15) and the power-on reset request (bit 16) each pulse high for exactly one cycle if enabled. Further expiries cause no further pulses.
- R8: An output whose enable bit is clear stays low through all stages.
- R9: A command write with bit 1 set disarms the watchdog and clears all outputs only if the immediately preceding register write put 0x0000C45A at offset 0xC. Any other write in between, or a stop without that key write, is ignored.
- R10: A command write with bit 0 set, when not an accepted stop, arms the watchdog and clears its expiry count, its stage and its outputs. This also applies when the watchdog is already armed.
- R11: Writes to offset 0x0 while armed leave the settings unchanged.
- R12: While disarmed, expiry pulses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Byte offset of the write |
| wrData | input | 32 | Write data |
| tmrExpire | input | 16 | One expiry pulse line per timer |
| cfgRd | output | 32 | Current settings word |
| irqLocal | output | 1 | Local interrupt, stage 1 and up |
| fiqLocal | output | 1 | Fast local interrupt, stage 2 and up |
| irqRemote | output | 1 | Remote interrupt, stage 2 and up |
| rstDebugReq | output | 1 | One-cycle debug reset request at stage 5 |
| rstPorReq | output | 1 | One-cycle power-on reset request at stage 5 |

## Verification
A stage counter that is off by one shows on the ports at the very next counted expiry:
- the local interrupt rises one expiry early or late;
- the fast local and remote interrupts appear with it instead of one stage later;
- the reset pulse arrives at the fourth or sixth expiry, or repeats.

A key latch that survives an intervening write shows as an unexpected drop of every interrupt in the cycle after the stop command. Settings that are not frozen show immediately on the read-back port.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_W     = 4;
  localparam int DATA_W     = 32;
  localparam int SRC_W      = 4;
  localparam int PERIOD_W   = 8;
  localparam int EN_W       = 5;
  localparam int CFG_W      = EN_W + PERIOD_W + SRC_W;
  localparam int PERIOD_LSB = SRC_W;
  localparam int EN_LSB     = SRC_W + PERIOD_W;

  localparam logic [ADDR_W-1:0] OFF_CFG = 4'h0;
  localparam logic [ADDR_W-1:0] OFF_CMD = 4'h8;
  localparam logic [ADDR_W-1:0] OFF_KEY = 4'hC;
  localparam logic [DATA_W-1:0] KEY_VAL = 32'h0000_C45A;

  // enable field, index within EN_W
  localparam int EN_IRQ = 0;
  localparam int EN_FIQ = 1;
  localparam int EN_REM = 2;
  localparam int EN_DBG = 3;
  localparam int EN_POR = 4;

  typedef struct packed {
    logic start;
    logic stop;
  } wdCmd_t;
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [CFG_W-1:0]  cfgReg,
  output logic              running,
  output wdCmd_t            cmd
);
  logic cfgWr, cmdWr, keyWr, keyOk;
  logic stopOk, startReq;

  assign cfgWr = wrEn && (wrAddr == OFF_CFG);
  assign cmdWr = wrEn && (wrAddr == OFF_CMD);
  assign keyWr = wrEn && (wrAddr == OFF_KEY);

  assign stopOk   = cmdWr && wrData[1] && keyOk;
  assign startReq = cmdWr && wrData[0] && !stopOk;

  assign cmd.start = startReq;
  assign cmd.stop  = stopOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg  <= '0;
      running <= 1'b0;
      keyOk   <= 1'b0;
    end else begin
      // any write consumes or replaces the key
      if (wrEn) keyOk <= keyWr && (wrData == KEY_VAL);
      if (cfgWr && !running) cfgReg <= wrData[CFG_W-1:0];
      if (stopOk) running <= 1'b0;
      else if (startReq) running <= 1'b1;
    end
  end

  // R11: settings frozen while armed
  a_r11_cfg_frozen: assert property (@(posedge clk) disable iff (!rstN)
    running |=> $stable(cfgReg));

  // R9: stop without key leaves an armed watchdog armed
  a_r9_stop_needs_key: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && wrData[1] && !keyOk && running) |=> running);
endmodule

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int NUM_SRC     = 16,
  parameter int FINAL_STAGE = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  wdCmd_t              cmd,
  input  logic                running,
  input  logic [SRC_W-1:0]    srcSel,
  input  logic [PERIOD_W-1:0] period,
  input  logic [EN_W-1:0]     enBits,
  input  logic [NUM_SRC-1:0]  tmrExpire,
  output logic                irqLocal,
  output logic                fiqLocal,
  output logic                irqRemote,
  output logic                rstDebugReq,
  output logic                rstPorReq
);
  localparam int STAGE_W = $clog2(FINAL_STAGE + 1);
  localparam logic [STAGE_W-1:0] LAST = STAGE_W'(FINAL_STAGE);
  localparam logic [STAGE_W-1:0] PRE  = STAGE_W'(FINAL_STAGE - 1);
  localparam logic [STAGE_W-1:0] ONE  = STAGE_W'(1);
  localparam logic [STAGE_W-1:0] TWO  = STAGE_W'(2);

  logic [NUM_SRC-1:0]  hitVec;
  logic                expHit;
  logic [PERIOD_W-1:0] expCnt;
  logic [STAGE_W-1:0]  stage;
  logic                dbgPulse, porPulse;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign hitVec[g] = tmrExpire[g] && (srcSel == SRC_W'(g));
  end

  assign expHit = running && (|hitVec) && (stage != LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      expCnt   <= '0;
      stage    <= '0;
      dbgPulse <= 1'b0;
      porPulse <= 1'b0;
    end else begin
      dbgPulse <= 1'b0;
      porPulse <= 1'b0;
      if (cmd.start || cmd.stop) begin
        expCnt <= '0;
        stage  <= '0;
      end else if (expHit) begin
        if (expCnt == period - PERIOD_W'(1)) begin
          expCnt <= '0;
          stage  <= stage + ONE;
          if (stage == PRE) begin
            dbgPulse <= enBits[EN_DBG];
            porPulse <= enBits[EN_POR];
          end
        end else begin
          expCnt <= expCnt + PERIOD_W'(1);
        end
      end
    end
  end

  assign irqLocal    = enBits[EN_IRQ] && (stage >= ONE);
  assign fiqLocal    = enBits[EN_FIQ] && (stage >= TWO);
  assign irqRemote   = enBits[EN_REM] && (stage >= TWO);
  assign rstDebugReq = dbgPulse;
  assign rstPorReq   = porPulse;

  // R4: stage never passes the last one
  a_r4_stage_bound: assert property (@(posedge clk) disable iff (!rstN)
    stage <= LAST);

  // R7: reset requests are single-cycle
  a_r7_por_single: assert property (@(posedge clk) disable iff (!rstN)
    rstPorReq |=> !rstPorReq);
  a_r7_dbg_single: assert property (@(posedge clk) disable iff (!rstN)
    rstDebugReq |=> !rstDebugReq);

  // R10: start clears the ladder
  a_r10_rearm: assert property (@(posedge clk) disable iff (!rstN)
    cmd.start |=> (stage == '0 && expCnt == '0));

  // R12: disarmed and no command keeps the stage
  a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !cmd.start && !cmd.stop) |=> $stable(stage));
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [3:0]  wrAddr,
  input  logic [31:0] wrData,
  input  logic [15:0] tmrExpire,
  output logic [31:0] cfgRd,
  output logic        irqLocal,
  output logic        fiqLocal,
  output logic        irqRemote,
  output logic        rstDebugReq,
  output logic        rstPorReq
);
  logic [CFG_W-1:0] cfgReg;
  logic             running;
  wdCmd_t           cmd;

  wdog_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cfgReg(cfgReg), .running(running), .cmd(cmd)
  );

  wdog_datapath #(.NUM_SRC(16), .FINAL_STAGE(5)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .running(running),
    .srcSel(cfgReg[SRC_W-1:0]),
    .period(cfgReg[PERIOD_LSB +: PERIOD_W]),
    .enBits(cfgReg[EN_LSB +: EN_W]),
    .tmrExpire(tmrExpire),
    .irqLocal(irqLocal), .fiqLocal(fiqLocal), .irqRemote(irqRemote),
    .rstDebugReq(rstDebugReq), .rstPorReq(rstPorReq)
  );

  assign cfgRd = {{(DATA_W-CFG_W){1'b0}}, cfgReg};
endmodule

// File: tb/tb_wdog_top.sv
module tb_wdog_top;
  logic        clk = 0;
  logic        rstN = 0;
  logic        wrEn = 0;
  logic [3:0]  wrAddr = 0;
  logic [31:0] wrData = 0;
  logic [15:0] tmrExpire = 0;
  logic [31:0] cfgRd;
  logic irqLocal, fiqLocal, irqRemote, rstDebugReq, rstPorReq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct {
    string      tag;
    logic [4:0] outExp;   // {por, dbg, remote, fiq, local}
    logic [31:0] cfgExp;
    bit         chkCfg;
  } item_t;
  item_t q[$];

  wdog_top dut (.*);

  always #5 clk = ~clk;

  // monitor: compares pending expectations away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        automatic item_t it = q.pop_front();
        automatic logic [4:0] got = {rstPorReq, rstDebugReq, irqRemote, fiqLocal, irqLocal};
        total++;
        if (got !== it.outExp) begin
          bad++;
          $display("FAIL %s outputs actual=%b expected=%b", it.tag, got, it.outExp);
        end
        if (it.chkCfg) begin
          total++;
          if (cfgRd !== it.cfgExp) begin
            bad++;
            $display("FAIL %s cfg actual=%h expected=%h", it.tag, cfgRd, it.cfgExp);
          end
        end
      end
    end
  end

  task automatic expect_out(string tag, logic [4:0] o);
    q.push_back('{tag, o, 32'h0, 1'b0});
  endtask

  task automatic expect_cfg(string tag, logic [4:0] o, logic [31:0] c);
    q.push_back('{tag, o, c, 1'b1});
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1; wrAddr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 0;
  endtask

  task automatic expire(int idx);
    @(negedge clk);
    tmrExpire = 16'h0;
    tmrExpire[idx] = 1'b1;
    @(posedge clk); #1;
    tmrExpire = 16'h0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic stopWd();
    wr(4'hC, 32'h0000C45A);
    wr(4'h8, 32'h2);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    expect_cfg("R1 reset", 5'b00000, 32'h0);
    tick();

    // R2: settings stored, upper bits dropped; all enables, period 1, source 2
    wr(4'h0, 32'hFFF1_F012);
    expect_cfg("R2 cfg store", 5'b00000, 32'h0001_F012);
    expire(2);
    expect_out("R12 disarmed expiry", 5'b00000);
    wr(4'h8, 32'h1);
    expire(0);
    expect_out("R3 other source", 5'b00000);
    expire(2);
    expect_out("R5 stage1", 5'b00001);
    expire(2);
    expect_out("R6 stage2", 5'b00111);
    expire(2);
    expire(2);
    expect_out("R6 stage4", 5'b00111);
    expire(2);
    expect_out("R7 stage5 pulse", 5'b11111);
    tick();
    expect_out("R7 pulse one cycle", 5'b00111);
    expire(2);
    expect_out("R7 no repeat", 5'b00111);

    wr(4'h0, 32'h0);
    expect_cfg("R11 cfg frozen", 5'b00111, 32'h0001_F012);
    wr(4'h8, 32'h2);
    expect_out("R9 stop without key", 5'b00111);
    wr(4'hC, 32'h0000C45A);
    wr(4'h0, 32'h0);
    wr(4'h8, 32'h2);
    expect_out("R9 key cancelled", 5'b00111);
    wr(4'hC, 32'h0000C45B);
    wr(4'h8, 32'h2);
    expect_out("R9 wrong key", 5'b00111);
    stopWd();
    expect_out("R9 stop accepted", 5'b00000);
    expire(2);
    expect_out("R12 stopped", 5'b00000);

    // R10: restart rearms
    wr(4'h8, 32'h1);
    expire(2);
    expect_out("R10 armed", 5'b00001);
    wr(4'h8, 32'h1);
    expect_out("R10 restart clears", 5'b00000);
    expire(2);
    expect_out("R10 restart count", 5'b00001);

    // R8: only power-on reset enabled, source 0
    stopWd();
    wr(4'h0, 32'h0001_0010);
    wr(4'h8, 32'h1);
    for (int i = 0; i < 4; i++) expire(0);
    expect_out("R8 disabled irqs", 5'b00000);
    expire(0);
    expect_out("R8 por only", 5'b10000);

    // R4: period 3, local interrupt only, source 1
    stopWd();
    wr(4'h0, 32'h0000_1031);
    wr(4'h8, 32'h1);
    expire(1); expire(1);
    expect_out("R4 period3 early", 5'b00000);
    expire(1);
    expect_out("R4 period3 stage1", 5'b00001);

    // R4: period 0 means 256
    stopWd();
    wr(4'h0, 32'h0000_1001);
    wr(4'h8, 32'h1);
    for (int i = 0; i < 255; i++) expire(1);
    expect_out("R4 period0 255", 5'b00000);
    expire(1);
    expect_out("R4 period0 256", 5'b00001);

    @(negedge clk); #1;
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule